// File: doc/BRIEF.md
# Tagged Address Translation Buffer

This block is a small, fully associative cache of address translations. Each slot pairs a virtual page tag with a page-table entry. The entry holds the physical page number, per-mode read and write enable masks, fault-on-read and fault-on-write flags, a global flag and an address-space number. A lookup port compares a virtual page number and the current address-space number against every slot in the same cycle. It returns hit/miss and the fields of the matching slot combinationally.

Fills arrive through an insert port. An insert that targets a slot already holding the same tag and address-space number rewrites that slot in place. Any other insert goes to the slot chosen by a round-robin pointer, and the pointer then moves on. An instruction-side fill clears the write mask. A fill with a non-zero granularity hint is refused and flagged on an error output.

Three invalidation commands each complete in one clock:
- Flush everything.
- Flush every non-global slot.
- Flush the one slot that matches a virtual page under the current address-space number.

Top module: `xlat_buffer`

## Requirements
- R1: `lk_hit_o` is high when some slot is valid, its tag equals `lk_va_i`, and either its ASN equals `cur_asn_i` or its global flag is set. On a hit, the `lk_*` fields carry that slot's stored values. On a miss they are all zero. A fill becomes visible to lookup in the cycle after its clock edge.
- R2: `flush_all_i` invalidates every slot at the next clock edge.
- R3: `flush_proc_i` invalidates every slot whose global flag is clear and keeps every global slot.
- R4: `flush_addr_i` invalidates only the slots whose tag equals `flush_va_i` and whose ASN equals `cur_asn_i` or whose global flag is set. A slot with the same tag under another ASN, not global, survives.
- R5: An insert with `ins_iside_i` = 1 stores a write mask of 4'b0000, whatever `ins_we_i` holds.
- R6: An insert with `ins_gh_i` != 2'b00 stores nothing. `ins_err_o` is high for exactly the one cycle after each clock edge at which `ins_valid_i` = 1 with a non-zero hint, and low otherwise.
- R7: An insert whose tag and ASN both equal those of a valid slot rewrites that slot and does not advance the replacement pointer.
- R8: Any other accepted insert writes the slot at the replacement pointer, then advances it. The pointer starts at slot 0 after reset and wraps from the last slot to slot 0. After N distinct fills from reset, the next fill evicts the first one.
- R9: Reset clears every valid bit, so every lookup misses after reset.
- R10: Only one operation takes effect per cycle. The priority order is flush-all, then flush-non-global, then single-address flush, then insert. An insert presented together with any flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_asn_i | input | 7 | Current address-space number for lookup and single-address flush |
| ins_valid_i | input | 1 | Insert request |
| ins_iside_i | input | 1 | Instruction-side fill; forces write mask to zero |
| ins_tag_i | input | 30 | Virtual page tag to insert |
| ins_ppn_i | input | 27 | Physical page number to insert |
| ins_re_i | input | 4 | Per-mode read enable mask |
| ins_we_i | input | 4 | Per-mode write enable mask |
| ins_for_i | input | 1 | Fault-on-read flag |
| ins_fow_i | input | 1 | Fault-on-write flag |
| ins_glob_i | input | 1 | Global flag |
| ins_asn_i | input | 7 | Address-space number of the fill |
| ins_gh_i | input | 2 | Granularity hint; non-zero is refused |
| ins_err_o | output | 1 | Refused insert, one cycle after the request |
| flush_all_i | input | 1 | Invalidate all slots |
| flush_proc_i | input | 1 | Invalidate non-global slots |
| flush_addr_i | input | 1 | Invalidate the slot matching flush_va_i |
| flush_va_i | input | 30 | Virtual page for single-address flush |
| lk_va_i | input | 30 | Virtual page to look up |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | 27 | Physical page number of the hit |
| lk_re_o | output | 4 | Read enable mask of the hit |
| lk_we_o | output | 4 | Write enable mask of the hit |
| lk_for_o | output | 1 | Fault-on-read flag of the hit |
| lk_fow_o | output | 1 | Fault-on-write flag of the hit |

## Verification
A stale or wrongly cleared valid bit appears at the lookup port in the first cycle after the offending edge, as a hit where a miss is due or the reverse. A slot written with wrong fields appears as a wrong page number or mask on the next lookup of that tag. A replacement pointer that drifts shows no symptom until the buffer wraps. Only then does the wrong translation get evicted, so pointer faults are probed by filling every slot from reset and then adding one more.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W  = 30;
  localparam int PPN_W  = 27;
  localparam int ASN_W  = 7;
  localparam int MASK_W = 4;
  localparam int GH_W   = 2;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [MASK_W-1:0] re;
    logic [MASK_W-1:0] we;
    logic              f_rd;
    logic              f_wr;
    logic              glob;
    logic [ASN_W-1:0]  asn;
  } pte_t;
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot
  import xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] wtag_i,
  input  pte_t             wpte_i,
  input  logic [VPN_W-1:0] lk_va_i,
  input  logic [ASN_W-1:0] cur_asn_i,
  input  logic [VPN_W-1:0] fl_va_i,
  input  logic [VPN_W-1:0] ins_tag_i,
  input  logic [ASN_W-1:0] ins_asn_i,
  output logic             valid_o,
  output logic             glob_o,
  output pte_t             pte_o,
  output logic             lk_hit_o,
  output logic             fl_hit_o,
  output logic             same_o
);
  logic             valid_q;
  logic [VPN_W-1:0] tag_q;
  pte_t             pte_q;
  logic             asn_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      pte_q   <= '0;
    end else if (inv_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      tag_q   <= wtag_i;
      pte_q   <= wpte_i;
    end
  end

  assign asn_ok   = (pte_q.asn == cur_asn_i) || pte_q.glob;
  assign lk_hit_o = valid_q && (tag_q == lk_va_i) && asn_ok;
  assign fl_hit_o = valid_q && (tag_q == fl_va_i) && asn_ok;
  assign same_o   = valid_q && (tag_q == ins_tag_i) && (pte_q.asn == ins_asn_i);
  assign valid_o  = valid_q;
  assign glob_o   = pte_q.glob;
  assign pte_o    = pte_q;
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/xlat_rr.sv
module xlat_rr #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASN_W-1:0]  cur_asn_i,
  input  logic              ins_valid_i,
  input  logic              ins_iside_i,
  input  logic [VPN_W-1:0]  ins_tag_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic [MASK_W-1:0] ins_re_i,
  input  logic [MASK_W-1:0] ins_we_i,
  input  logic              ins_for_i,
  input  logic              ins_fow_i,
  input  logic              ins_glob_i,
  input  logic [ASN_W-1:0]  ins_asn_i,
  input  logic [GH_W-1:0]   ins_gh_i,
  output logic              ins_err_o,
  input  logic              flush_all_i,
  input  logic              flush_proc_i,
  input  logic              flush_addr_i,
  input  logic [VPN_W-1:0]  flush_va_i,
  input  logic [VPN_W-1:0]  lk_va_i,
  output logic              lk_hit_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [MASK_W-1:0] lk_re_o,
  output logic [MASK_W-1:0] lk_we_o,
  output logic              lk_for_o,
  output logic              lk_fow_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0] valid_q, glob_q, lk_hit, fl_hit, same_hit, wr, inv;
  pte_t                 pte_arr [N_ENTRIES];
  pte_t                 wpte, hit_pte;
  logic [IDX_W-1:0]     lk_idx, same_idx, victim;
  logic                 lk_any, same_any;
  logic                 any_flush, gh_bad, ins_take, alloc;
  logic                 err_q;

  assign any_flush = flush_all_i | flush_proc_i | flush_addr_i;
  assign gh_bad    = ins_valid_i && (ins_gh_i != '0);
  assign ins_take  = ins_valid_i && !gh_bad && !any_flush;
  assign alloc     = ins_take && !same_any;

  always_comb begin
    wpte.ppn  = ins_ppn_i;
    wpte.re   = ins_re_i;
    wpte.we   = ins_iside_i ? '0 : ins_we_i;
    wpte.f_rd = ins_for_i;
    wpte.f_wr = ins_fow_i;
    wpte.glob = ins_glob_i;
    wpte.asn  = ins_asn_i;
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    always_comb begin
      if (flush_all_i)       inv[i] = 1'b1;
      else if (flush_proc_i) inv[i] = !glob_q[i];
      else if (flush_addr_i) inv[i] = fl_hit[i];
      else                   inv[i] = 1'b0;
    end
    assign wr[i] = ins_take && (same_any ? (same_idx == IDX_W'(i))
                                         : (victim == IDX_W'(i)));

    xlat_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr[i]),
      .inv_i     (inv[i]),
      .wtag_i    (ins_tag_i),
      .wpte_i    (wpte),
      .lk_va_i   (lk_va_i),
      .cur_asn_i (cur_asn_i),
      .fl_va_i   (flush_va_i),
      .ins_tag_i (ins_tag_i),
      .ins_asn_i (ins_asn_i),
      .valid_o   (valid_q[i]),
      .glob_o    (glob_q[i]),
      .pte_o     (pte_arr[i]),
      .lk_hit_o  (lk_hit[i]),
      .fl_hit_o  (fl_hit[i]),
      .same_o    (same_hit[i])
    );
  end

  xlat_pick #(.N(N_ENTRIES)) u_lk_pick (
    .req_i (lk_hit),
    .any_o (lk_any),
    .idx_o (lk_idx)
  );

  xlat_pick #(.N(N_ENTRIES)) u_same_pick (
    .req_i (same_hit),
    .any_o (same_any),
    .idx_o (same_idx)
  );

  xlat_rr #(.N(N_ENTRIES)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (alloc),
    .ptr_o  (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= gh_bad;
  end
  assign ins_err_o = err_q;

  assign hit_pte  = lk_any ? pte_arr[lk_idx] : '0;
  assign lk_hit_o = lk_any;
  assign lk_ppn_o = hit_pte.ppn;
  assign lk_re_o  = hit_pte.re;
  assign lk_we_o  = hit_pte.we;
  assign lk_for_o = hit_pte.f_rd;
  assign lk_fow_o = hit_pte.f_wr;
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_all_i,
  input logic                 flush_proc_i,
  input logic                 flush_addr_i,
  input logic                 ins_valid_i,
  input logic [GH_W-1:0]      ins_gh_i,
  input logic                 ins_err_o,
  input logic                 lk_hit_o,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] glob_q
);
  a_r2_flush_all_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0) && !lk_hit_o);

  a_r3_proc_keeps_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !flush_all_i) |=> valid_q == $past(valid_q & glob_q));

  a_r6_err_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_gh_i != '0) |=> ins_err_o);

  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_valid_i && ins_gh_i != '0) |=> !ins_err_o);

  a_r8_single_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(valid_q) <= $past($countones(valid_q)) + 1);

  a_r10_flush_blocks_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_addr_i || flush_proc_i || flush_all_i) |=> $countones(valid_q) <= $past($countones(valid_q)));

  a_r1_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> valid_q != '0);
endmodule

bind xlat_buffer xlat_buffer_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_all_i  (flush_all_i),
  .flush_proc_i (flush_proc_i),
  .flush_addr_i (flush_addr_i),
  .ins_valid_i  (ins_valid_i),
  .ins_gh_i     (ins_gh_i),
  .ins_err_o    (ins_err_o),
  .lk_hit_o     (lk_hit_o),
  .valid_q      (valid_q),
  .glob_q       (glob_q)
);

// File: tb/xlat_buffer_tb_top.sv
module xlat_buffer_tb_top;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  cur_asn_i = '0;
  logic        ins_valid_i = 1'b0, ins_iside_i = 1'b0;
  logic [29:0] ins_tag_i = '0;
  logic [26:0] ins_ppn_i = '0;
  logic [3:0]  ins_re_i = '0, ins_we_i = '0;
  logic        ins_for_i = 1'b0, ins_fow_i = 1'b0, ins_glob_i = 1'b0;
  logic [6:0]  ins_asn_i = '0;
  logic [1:0]  ins_gh_i = '0;
  logic        ins_err_o;
  logic        flush_all_i = 1'b0, flush_proc_i = 1'b0, flush_addr_i = 1'b0;
  logic [29:0] flush_va_i = '0;
  logic [29:0] lk_va_i = '0;
  logic        lk_hit_o;
  logic [26:0] lk_ppn_o;
  logic [3:0]  lk_re_o, lk_we_o;
  logic        lk_for_o, lk_fow_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  xlat_buffer #(.N_ENTRIES(N)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic insert(input logic [29:0] tag, input logic [26:0] ppn,
                        input logic [3:0] re, input logic [3:0] we,
                        input bit glob, input logic [6:0] asn,
                        input bit iside, input logic [1:0] gh);
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_tag_i = tag; ins_ppn_i = ppn; ins_re_i = re;
    ins_we_i = we; ins_glob_i = glob; ins_asn_i = asn; ins_iside_i = iside;
    ins_gh_i = gh; ins_for_i = ppn[0]; ins_fow_i = ppn[1];
    @(negedge clk_i);
    ins_valid_i = 1'b0; ins_gh_i = '0; ins_iside_i = 1'b0;
  endtask

  task automatic flush(input bit all, input bit proc, input bit addr,
                       input logic [29:0] va, input logic [6:0] asn);
    @(negedge clk_i);
    flush_all_i = all; flush_proc_i = proc; flush_addr_i = addr;
    flush_va_i = va; cur_asn_i = asn;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_proc_i = 1'b0; flush_addr_i = 1'b0;
  endtask

  task automatic look(input logic [29:0] va, input logic [6:0] asn,
                      input bit exp_hit, input logic [26:0] exp_ppn,
                      input string req);
    lk_va_i = va; cur_asn_i = asn;
    #1;
    check(lk_hit_o == exp_hit, req, "hit", 64'(lk_hit_o), 64'(exp_hit));
    if (exp_hit)
      check(lk_ppn_o == exp_ppn, req, "ppn", 64'(lk_ppn_o), 64'(exp_ppn));
  endtask

  task automatic t_reset();
    do_reset();
    look(30'h100, 7'd0, 1'b0, '0, "R9");
    check(ins_err_o == 1'b0, "R9", "err after reset", 64'(ins_err_o), 64'd0);
  endtask

  task automatic t_basic();
    insert(30'h1234, 27'h5555, 4'ha, 4'h5, 1'b0, 7'd3, 1'b0, 2'd0);
    look(30'h1234, 7'd3, 1'b1, 27'h5555, "R1");
    check(lk_re_o == 4'ha && lk_we_o == 4'h5, "R1", "masks",
          64'({lk_re_o, lk_we_o}), 64'h a5);
    check(lk_for_o == 1'b1 && lk_fow_o == 1'b0, "R1", "fault flags",
          64'({lk_for_o, lk_fow_o}), 64'h2);
    look(30'h1234, 7'd4, 1'b0, '0, "R1");
    check(lk_ppn_o == '0, "R1", "ppn zero on miss", 64'(lk_ppn_o), 64'd0);
    insert(30'h2000, 27'h0abc, 4'h3, 4'h3, 1'b1, 7'd9, 1'b0, 2'd0);
    look(30'h2000, 7'd1, 1'b1, 27'h0abc, "R1");
  endtask

  task automatic t_iside();
    insert(30'h3000, 27'h0777, 4'hf, 4'hf, 1'b0, 7'd3, 1'b1, 2'd0);
    look(30'h3000, 7'd3, 1'b1, 27'h0777, "R5");
    check(lk_we_o == 4'h0, "R5", "we forced zero", 64'(lk_we_o), 64'd0);
    check(lk_re_o == 4'hf, "R5", "re kept", 64'(lk_re_o), 64'hf);
  endtask

  task automatic t_gh();
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_tag_i = 30'h4000; ins_ppn_i = 27'h1; ins_asn_i = 7'd3;
    ins_gh_i = 2'd2; ins_glob_i = 1'b0; ins_iside_i = 1'b0;
    @(negedge clk_i);
    ins_valid_i = 1'b0; ins_gh_i = '0;
    check(ins_err_o == 1'b1, "R6", "err raised", 64'(ins_err_o), 64'd1);
    look(30'h4000, 7'd3, 1'b0, '0, "R6");
    @(negedge clk_i);
    check(ins_err_o == 1'b0, "R6", "err one cycle", 64'(ins_err_o), 64'd0);
  endtask

  task automatic t_flush_addr();
    insert(30'h5000, 27'h11, 4'h1, 4'h1, 1'b0, 7'd1, 1'b0, 2'd0);
    insert(30'h5000, 27'h22, 4'h1, 4'h1, 1'b0, 7'd2, 1'b0, 2'd0);
    insert(30'h6000, 27'h33, 4'h1, 4'h1, 1'b1, 7'd3, 1'b0, 2'd0);
    flush(1'b0, 1'b0, 1'b1, 30'h5000, 7'd1);
    look(30'h5000, 7'd1, 1'b0, '0, "R4");
    look(30'h5000, 7'd2, 1'b1, 27'h22, "R4");
    flush(1'b0, 1'b0, 1'b1, 30'h6000, 7'd5);
    look(30'h6000, 7'd3, 1'b0, '0, "R4");
    look(30'h1234, 7'd3, 1'b1, 27'h5555, "R4");
  endtask

  task automatic t_flush_proc();
    flush(1'b0, 1'b1, 1'b0, '0, 7'd0);
    look(30'h2000, 7'd1, 1'b1, 27'h0abc, "R3");
    look(30'h1234, 7'd3, 1'b0, '0, "R3");
    look(30'h5000, 7'd2, 1'b0, '0, "R3");
  endtask

  task automatic t_priority();
    // insert alongside a flush is dropped
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_tag_i = 30'h7000; ins_ppn_i = 27'h44; ins_asn_i = 7'd3;
    ins_glob_i = 1'b1; ins_gh_i = '0; ins_iside_i = 1'b0;
    flush_addr_i = 1'b1; flush_va_i = 30'h0; cur_asn_i = 7'd3;
    @(negedge clk_i);
    ins_valid_i = 1'b0; flush_addr_i = 1'b0;
    look(30'h7000, 7'd3, 1'b0, '0, "R10");
    look(30'h2000, 7'd1, 1'b1, 27'h0abc, "R10");
    // flush_all overrides flush_proc keep-global rule
    @(negedge clk_i);
    flush_all_i = 1'b1; flush_proc_i = 1'b1;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_proc_i = 1'b0;
    look(30'h2000, 7'd1, 1'b0, '0, "R10");
  endtask

  task automatic t_flush_all();
    insert(30'h8000, 27'h55, 4'h1, 4'h1, 1'b1, 7'd0, 1'b0, 2'd0);
    insert(30'h8001, 27'h56, 4'h1, 4'h1, 1'b0, 7'd0, 1'b0, 2'd0);
    flush(1'b1, 1'b0, 1'b0, '0, 7'd0);
    look(30'h8000, 7'd0, 1'b0, '0, "R2");
    look(30'h8001, 7'd0, 1'b0, '0, "R2");
  endtask

  task automatic t_replace();
    do_reset();
    insert(30'h100, 27'h1, 4'h1, 4'h0, 1'b0, 7'd5, 1'b0, 2'd0);
    insert(30'h100, 27'h2, 4'h1, 4'h0, 1'b0, 7'd5, 1'b0, 2'd0);
    look(30'h100, 7'd5, 1'b1, 27'h2, "R7");
    for (int k = 1; k < N; k++)
      insert(30'h200 + 30'(k), 27'h100 + 27'(k), 4'h1, 4'h0, 1'b0, 7'd5, 1'b0, 2'd0);
    look(30'h100, 7'd5, 1'b1, 27'h2, "R7");
    for (int k = 1; k < N; k++)
      look(30'h200 + 30'(k), 7'd5, 1'b1, 27'h100 + 27'(k), "R8");
    insert(30'h300, 27'h77, 4'h1, 4'h0, 1'b0, 7'd5, 1'b0, 2'd0);
    look(30'h100, 7'd5, 1'b0, '0, "R8");
    look(30'h201, 7'd5, 1'b1, 27'h101, "R8");
    look(30'h300, 7'd5, 1'b1, 27'h77, "R8");
    insert(30'h301, 27'h78, 4'h1, 4'h0, 1'b0, 7'd5, 1'b0, 2'd0);
    look(30'h201, 7'd5, 1'b0, '0, "R8");
    look(30'h202, 7'd5, 1'b1, 27'h102, "R8");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_iside();
    t_gh();
    t_flush_addr();
    t_flush_proc();
    t_priority();
    t_flush_all();
    t_replace();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule